// File: doc/BRIEF.md
# Serial Core Test Wrapper with Command Decode

This block sits around a logic core that carries its own built-in self-test engine. It exposes one serial test port: a serial input, a serial output, a test clock, an active-low reset and four control strobes (register select, capture, shift, update). An external test controller, normally a boundary-scan TAP, drives these strobes to load a 3-bit instruction and then capture, shift and update whichever data register that instruction selects.

The wrapper has three standard registers: the instruction register, a one-bit bypass register and a boundary register on the core's pins. It adds two more. The first is a 16-bit command register. Its update makes a small sequencer do one of four things: reset the self-test engine, start it with a pattern count, choose which result the engine should present, or nothing. The second is a read-only result register. It captures the engine's busy and done flags, its signature and the current result choice. A full self-test therefore runs from serial commands alone, with no stored test vectors.

The command sequencer has four states:
- `CS_IDLE`: waiting.
- `CS_RESET`: drives the engine reset.
- `CS_START`: drives the start strobe and latches the pattern count.
- `CS_SELECT`: latches the result select.

An update of the command register moves `CS_IDLE` (or any other state) to the state named by the opcode. A NOP opcode, or no update at all, moves to `CS_IDLE`. Each non-idle state lasts exactly one clock.

Top module: `wrp_core_wrapper`

## Requirements
- R1: While `wrstn` is low, all of the following hold, asynchronously: the instruction is BYPASS (000), the command register and all shift stages are cleared, the sequencer is in `CS_IDLE`, and `pattern_count_o`, `result_sel_o`, `bnd_upd_o`, `bist_reset_o` and `bist_start_o` are all zero.
- R2: While `sel_wir` is high, the strobes act on the instruction register only.
  - Capture loads 3'b101.
  - Shift moves one bit per rising `wrck`, least significant bit first, from `wsi` toward `wso`.
  - Update makes the shifted value the new instruction.
  - No data register changes.
- R3: Instruction codes 000 and every code from 100 to 111 select the one-bit bypass register. Capture loads 0 into it, and during a shift `wso` gives `wsi` delayed by one clock.
- R4: Code 001 selects the boundary register and raises `ext_mode_o`.
  - Capture loads `bnd_cap_i`.
  - Update drives the shifted value onto `bnd_upd_o`.
  - An update issued under any other instruction leaves `bnd_upd_o` unchanged.
- R5: Code 010 selects the 16-bit command register. Its fields are: bits [1:0] opcode, bits [13:2] pattern count, bits [15:14] result select. Capture loads the last updated command word.
- R6: Opcode 10 (start) holds `bist_start_o` high for exactly the one clock after the update edge. From the following edge, `pattern_count_o` equals bits [13:2] of the command word.
- R7: Opcode 01 (reset) holds `bist_reset_o` high for exactly the one clock after the update edge. It changes neither `pattern_count_o` nor `result_sel_o`.
- R8: Opcode 11 (select) sets `result_sel_o` to bits [15:14] of the command word one clock after the update edge. It raises neither strobe.
- R9: Opcode 00 (nop) raises no strobe and changes no output.
- R10: Code 011 selects the 20-bit result register. Capture loads, from most to least significant bit: `result_sel_o` [19:18], `bist_busy_i` [17], `bist_done_i` [16] and `bist_sig_i` [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrck | input | 1 | Test clock; all registers act on its rising edge |
| wrstn | input | 1 | Asynchronous active-low reset |
| wsi | input | 1 | Serial data in |
| wso | output | 1 | Serial data out (LSB of the selected register) |
| sel_wir | input | 1 | High: strobes target the instruction register |
| capture_wr | input | 1 | Capture strobe |
| shift_wr | input | 1 | Shift strobe |
| update_wr | input | 1 | Update strobe |
| bnd_cap_i | input | 8 | Core pin values captured by the boundary register |
| bnd_upd_o | output | 8 | Boundary values driven while in external test |
| ext_mode_o | output | 1 | External test instruction active |
| bist_busy_i | input | 1 | Self-test engine busy flag |
| bist_done_i | input | 1 | Self-test engine done flag |
| bist_sig_i | input | 16 | Selected signature from the engine |
| bist_reset_o | output | 1 | One-clock reset strobe to the engine |
| bist_start_o | output | 1 | One-clock start strobe to the engine |
| pattern_count_o | output | 12 | Pattern count latched at start |
| result_sel_o | output | 2 | Result choice for the engine's output selector |

## Verification
The embedded properties check the following on every clock:
- A parallel register moves only on an update aimed at it.
- The start strobe lasts one clock.
- The pattern count moves only after a start.
- The result select moves only in `CS_SELECT`.
- A nop leads back to idle.
- The bypass path gives a one-clock delay from `wsi` to `wso`.

Some behaviour needs whole scan sequences and is left to the bench scenarios:
- The capture values of each register.
- The bit ordering of the fields.
- Unknown instruction codes acting as bypass.
- The command word read back on capture.
- Recovery after a mid-run reset.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 3'b101;

    localparam logic [IR_W-1:0] INS_BYPASS = 3'b000;
    localparam logic [IR_W-1:0] INS_EXTEST = 3'b001;
    localparam logic [IR_W-1:0] INS_CMD    = 3'b010;
    localparam logic [IR_W-1:0] INS_READ   = 3'b011;

    typedef enum logic [1:0] {
        DR_BYP,
        DR_BND,
        DR_CMD,
        DR_RDR
    } dr_sel_e;

    typedef enum logic [1:0] {
        OP_NOP    = 2'b00,
        OP_RESET  = 2'b01,
        OP_START  = 2'b10,
        OP_SELECT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_RESET,
        CS_START,
        CS_SELECT
    } cs_e;

endpackage

// File: rtl/wrp_chain.sv
module wrp_chain #(
    parameter int W       = 8,
    parameter bit HAS_UPD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         shf_en,
    input  logic         upd_en,
    input  logic         si,
    input  logic [W-1:0] cap_val,
    output logic         so,
    output logic [W-1:0] upd_q
);

    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (cap_en) begin
            sh_q <= cap_val;
        end else if (shf_en) begin
            if (W == 1) sh_q <= si;
            else        sh_q <= {si, sh_q[W-1:1]};
        end
    end

    assign so = sh_q[0];

    generate
        if (HAS_UPD) begin : g_upd
            logic [W-1:0] par_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      par_q <= '0;
                else if (upd_en) par_q <= sh_q;
            end
            assign upd_q = par_q;

            // R2 R4 R5
            upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en |=> $stable(par_q));
        end else begin : g_noupd
            assign upd_q = '0;
        end
    endgenerate

endmodule

// File: rtl/wrp_ir.sv
module wrp_ir
    import wrp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_wir,
    input  logic    capture_wr,
    input  logic    shift_wr,
    input  logic    update_wr,
    input  logic    si,
    output logic    so,
    output dr_sel_e dr_sel,
    output logic    ext_mode
);

    logic [IR_W-1:0] ins_q;

    wrp_chain #(.W(IR_W), .HAS_UPD(1'b1)) u_ir_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (sel_wir & capture_wr),
        .shf_en  (sel_wir & shift_wr),
        .upd_en  (sel_wir & update_wr),
        .si      (si),
        .cap_val (IR_CAPTURE_VAL),
        .so      (so),
        .upd_q   (ins_q)
    );

    always_comb begin
        unique case (ins_q)
            INS_EXTEST: dr_sel = DR_BND;
            INS_CMD:    dr_sel = DR_CMD;
            INS_READ:   dr_sel = DR_RDR;
            default:    dr_sel = DR_BYP;
        endcase
    end

    assign ext_mode = (dr_sel == DR_BND);

endmodule

// File: rtl/wrp_cmd_fsm.sv
module wrp_cmd_fsm
    import wrp_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int RSEL_W = 2,
    localparam int CMD_W = 2 + CNT_W + RSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_cmd,
    input  logic [CMD_W-1:0]  new_word,
    input  logic [CMD_W-1:0]  cur_word,
    output logic              bist_reset_o,
    output logic              bist_start_o,
    output logic [CNT_W-1:0]  pat_cnt,
    output logic [RSEL_W-1:0] res_sel
);

    cs_e cs_q, cs_nxt;
    op_e new_op;

    assign new_op = op_e'(new_word[1:0]);

    always_comb begin
        cs_nxt = CS_IDLE;
        if (upd_cmd) begin
            unique case (new_op)
                OP_RESET:  cs_nxt = CS_RESET;
                OP_START:  cs_nxt = CS_START;
                OP_SELECT: cs_nxt = CS_SELECT;
                default:   cs_nxt = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= CS_IDLE;
        else        cs_q <= cs_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_cnt <= '0;
            res_sel <= '0;
        end else begin
            unique case (cs_q)
                CS_START:  pat_cnt <= cur_word[2 +: CNT_W];
                CS_SELECT: res_sel <= cur_word[2+CNT_W +: RSEL_W];
                default: ;
            endcase
        end
    end

    assign bist_reset_o = (cs_q == CS_RESET);
    assign bist_start_o = (cs_q == CS_START);

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bist_start_o && !upd_cmd |=> !bist_start_o);
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_start_o |=> $stable(pat_cnt));
    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q != CS_SELECT) |=> $stable(res_sel));
    // R9
    nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_cmd && (new_word[1:0] == 2'b00) |=> (!bist_start_o && !bist_reset_o));

endmodule

// File: rtl/wrp_core_wrapper.sv
module wrp_core_wrapper
    import wrp_pkg::*;
#(
    parameter int BND_W  = 8,
    parameter int SIG_W  = 16,
    parameter int CNT_W  = 12,
    parameter int RSEL_W = 2,
    localparam int CMD_W = 2 + CNT_W + RSEL_W,
    localparam int RDR_W = SIG_W + 2 + RSEL_W
) (
    input  logic              wrck,
    input  logic              wrstn,
    input  logic              wsi,
    output logic              wso,
    input  logic              sel_wir,
    input  logic              capture_wr,
    input  logic              shift_wr,
    input  logic              update_wr,
    input  logic [BND_W-1:0]  bnd_cap_i,
    output logic [BND_W-1:0]  bnd_upd_o,
    output logic              ext_mode_o,
    input  logic              bist_busy_i,
    input  logic              bist_done_i,
    input  logic [SIG_W-1:0]  bist_sig_i,
    output logic              bist_reset_o,
    output logic              bist_start_o,
    output logic [CNT_W-1:0]  pattern_count_o,
    output logic [RSEL_W-1:0] result_sel_o
);

    dr_sel_e    dr_sel;
    logic       ir_so, byp_so, bnd_so, cmd_so, rdr_so;
    logic [3:0] dr_cap, dr_shf, dr_upd;
    logic [CMD_W-1:0] cmd_word, cmd_shift;
    logic [0:0] byp_unused;
    logic [RDR_W-1:0] rdr_unused;

    wrp_ir u_ir (
        .clk        (wrck),
        .rst_n      (wrstn),
        .sel_wir    (sel_wir),
        .capture_wr (capture_wr),
        .shift_wr   (shift_wr),
        .update_wr  (update_wr),
        .si         (wsi),
        .so         (ir_so),
        .dr_sel     (dr_sel),
        .ext_mode   (ext_mode_o)
    );

    generate
        for (genvar g = 0; g < 4; g++) begin : g_en
            assign dr_cap[g] = !sel_wir && capture_wr && (dr_sel == dr_sel_e'(g));
            assign dr_shf[g] = !sel_wir && shift_wr   && (dr_sel == dr_sel_e'(g));
            assign dr_upd[g] = !sel_wir && update_wr  && (dr_sel == dr_sel_e'(g));
        end
    endgenerate

    wrp_chain #(.W(1), .HAS_UPD(1'b0)) u_byp (
        .clk (wrck), .rst_n (wrstn),
        .cap_en (dr_cap[DR_BYP]), .shf_en (dr_shf[DR_BYP]), .upd_en (1'b0),
        .si (wsi), .cap_val (1'b0), .so (byp_so), .upd_q (byp_unused)
    );

    wrp_chain #(.W(BND_W), .HAS_UPD(1'b1)) u_bnd (
        .clk (wrck), .rst_n (wrstn),
        .cap_en (dr_cap[DR_BND]), .shf_en (dr_shf[DR_BND]), .upd_en (dr_upd[DR_BND]),
        .si (wsi), .cap_val (bnd_cap_i), .so (bnd_so), .upd_q (bnd_upd_o)
    );

    wrp_chain #(.W(CMD_W), .HAS_UPD(1'b1)) u_cmd (
        .clk (wrck), .rst_n (wrstn),
        .cap_en (dr_cap[DR_CMD]), .shf_en (dr_shf[DR_CMD]), .upd_en (dr_upd[DR_CMD]),
        .si (wsi), .cap_val (cmd_word), .so (cmd_so), .upd_q (cmd_word)
    );

    // The command chain keeps its shift contents in the stages behind so;
    // the sequencer needs the value being updated, rebuilt from a mirror.
    logic [CMD_W-1:0] cmd_mirror;
    always_ff @(posedge wrck or negedge wrstn) begin
        if (!wrstn)                  cmd_mirror <= '0;
        else if (dr_cap[DR_CMD])     cmd_mirror <= cmd_word;
        else if (dr_shf[DR_CMD])     cmd_mirror <= {wsi, cmd_mirror[CMD_W-1:1]};
    end
    assign cmd_shift = cmd_mirror;

    wrp_chain #(.W(RDR_W), .HAS_UPD(1'b0)) u_rdr (
        .clk (wrck), .rst_n (wrstn),
        .cap_en (dr_cap[DR_RDR]), .shf_en (dr_shf[DR_RDR]), .upd_en (1'b0),
        .si (wsi), .cap_val ({result_sel_o, bist_busy_i, bist_done_i, bist_sig_i}),
        .so (rdr_so), .upd_q (rdr_unused)
    );

    wrp_cmd_fsm #(.CNT_W(CNT_W), .RSEL_W(RSEL_W)) u_fsm (
        .clk          (wrck),
        .rst_n        (wrstn),
        .upd_cmd      (dr_upd[DR_CMD]),
        .new_word     (cmd_shift),
        .cur_word     (cmd_word),
        .bist_reset_o (bist_reset_o),
        .bist_start_o (bist_start_o),
        .pat_cnt      (pattern_count_o),
        .res_sel      (result_sel_o)
    );

    always_comb begin
        if (sel_wir) begin
            wso = ir_so;
        end else begin
            unique case (dr_sel)
                DR_BND:  wso = bnd_so;
                DR_CMD:  wso = cmd_so;
                DR_RDR:  wso = rdr_so;
                default: wso = byp_so;
            endcase
        end
    end

    // R3
    byp_delay_chk: assert property (@(posedge wrck) disable iff (!wrstn)
        shift_wr && !capture_wr && !sel_wir && (dr_sel == DR_BYP)
        |=> (sel_wir || (wso == $past(wsi))));
    // R4
    bnd_hold_chk: assert property (@(posedge wrck) disable iff (!wrstn)
        !(update_wr && !sel_wir && ext_mode_o) |=> $stable(bnd_upd_o));

endmodule

// File: tb/wrp_core_wrapper_bench.sv
module wrp_core_wrapper_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BND_W = 8;
    localparam int SIG_W = 16;

    logic wrck = 1'b0;
    logic wrstn = 1'b0;
    logic wsi = 1'b0, sel_wir = 1'b0, capture_wr = 1'b0, shift_wr = 1'b0, update_wr = 1'b0;
    logic wso;
    logic [BND_W-1:0] bnd_cap_i = '0;
    logic [BND_W-1:0] bnd_upd_o;
    logic ext_mode_o;
    logic bist_busy_i = 1'b0, bist_done_i = 1'b0;
    logic [SIG_W-1:0] bist_sig_i = '0;
    logic bist_reset_o, bist_start_o;
    logic [11:0] pattern_count_o;
    logic [1:0] result_sel_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [1:0] obs1, obs2;
    logic [11:0] m_cnt = '0;
    logic [1:0]  m_sel = '0;
    logic [15:0] m_word = '0;
    logic [BND_W-1:0] m_bnd = '0;

    wrp_core_wrapper u_wrp_core_wrapper (
        .wrck (wrck), .wrstn (wrstn), .wsi (wsi), .wso (wso),
        .sel_wir (sel_wir), .capture_wr (capture_wr), .shift_wr (shift_wr), .update_wr (update_wr),
        .bnd_cap_i (bnd_cap_i), .bnd_upd_o (bnd_upd_o), .ext_mode_o (ext_mode_o),
        .bist_busy_i (bist_busy_i), .bist_done_i (bist_done_i), .bist_sig_i (bist_sig_i),
        .bist_reset_o (bist_reset_o), .bist_start_o (bist_start_o),
        .pattern_count_o (pattern_count_o), .result_sel_o (result_sel_o)
    );

    always #(CLK_PERIOD/2) wrck = ~wrck;

    function automatic logic [15:0] pack_cmd(logic [1:0] op, logic [11:0] cnt, logic [1:0] sel);
        return {sel, cnt, op};
    endfunction

    function automatic logic [19:0] exp_rdr(logic [1:0] sel, logic busy, logic done, logic [15:0] sig);
        return {sel, busy, done, sig};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one capture / shift(len) / optional update sequence
    task automatic scan(input bit ir, input int len, input logic [31:0] din,
                        input bit do_upd, output logic [31:0] dout);
        dout = '0;
        @(negedge wrck);
        sel_wir = ir; capture_wr = 1'b1;
        @(negedge wrck);
        capture_wr = 1'b0; shift_wr = 1'b1;
        for (int i = 0; i < len; i++) begin
            wsi = din[i];
            dout[i] = wso;
            @(negedge wrck);
        end
        shift_wr = 1'b0;
        if (do_upd) begin
            update_wr = 1'b1;
            @(negedge wrck);
            update_wr = 1'b0;
        end
        obs1 = {bist_reset_o, bist_start_o};
        @(negedge wrck);
        obs2 = {bist_reset_o, bist_start_o};
        sel_wir = 1'b0;
    endtask

    task automatic load_ir(input logic [2:0] code);
        logic [31:0] d;
        scan(1'b1, 3, {29'd0, code}, 1'b1, d);
        check("R2 ir capture", d[2:0], 3'b101);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [11:0] cnt, input logic [1:0] sel);
        logic [31:0] d;
        logic [15:0] w;
        w = pack_cmd(op, cnt, sel);
        scan(1'b0, 16, {16'd0, w}, 1'b1, d);
        check("R5 cmd readback", d[15:0], m_word);
        m_word = w;
        check("R6 R7 strobes cycle1", obs1, {op == 2'b01, op == 2'b10});
        check("R6 R7 strobes cycle2", obs2, 2'b00);
        if (op == 2'b10) m_cnt = cnt;
        if (op == 2'b11) m_sel = sel;
        check("R6 R7 R9 pattern count", pattern_count_o, m_cnt);
        check("R8 R7 R9 result select", result_sel_o, m_sel);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge wrck);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        void'($urandom(32'h1500));

        // R1 reset state
        repeat (3) @(negedge wrck);
        check("R1 wso", wso, 1'b0);
        check("R1 outputs", {bist_reset_o, bist_start_o, pattern_count_o, result_sel_o, bnd_upd_o, ext_mode_o}, '0);
        wrstn = 1'b1;
        @(negedge wrck);

        // R3 bypass after reset
        r = $urandom();
        scan(1'b0, 8, r, 1'b0, d);
        check("R3 bypass after reset", d[7:0], {r[6:0], 1'b0});

        // R4 boundary
        load_ir(3'b001);
        check("R4 ext mode", ext_mode_o, 1'b1);
        bnd_cap_i = 8'hA5;
        r = $urandom();
        scan(1'b0, 8, r, 1'b1, d);
        check("R4 bnd capture", d[7:0], 8'hA5);
        m_bnd = r[7:0];
        check("R4 bnd update", bnd_upd_o, m_bnd);

        // R3 unknown codes act as bypass; R4 update ignored outside extest
        for (int c = 4; c < 8; c++) begin
            load_ir(c[2:0]);
            check("R3 ext mode low", ext_mode_o, 1'b0);
            r = $urandom();
            scan(1'b0, 8, r, 1'b1, d);
            check("R3 unknown code bypass", d[7:0], {r[6:0], 1'b0});
            check("R4 bnd unchanged", bnd_upd_o, m_bnd);
        end

        // R5..R9 command register directed then random
        load_ir(3'b010);
        send_cmd(2'b00, 12'h123, 2'b10);
        send_cmd(2'b10, 12'hFFF, 2'b01);
        send_cmd(2'b11, 12'h000, 2'b11);
        send_cmd(2'b01, 12'h555, 2'b00);
        for (int k = 0; k < 30; k++) begin
            logic [31:0] x;
            x = $urandom();
            send_cmd(x[1:0], x[13:2], x[15:14]);
        end

        // R2 instruction scan leaves data registers alone
        load_ir(3'b010);
        scan(1'b0, 16, 32'h0, 1'b0, d);
        check("R2 cmd kept across ir scan", d[15:0], m_word);

        // R10 result register
        load_ir(3'b011);
        for (int k = 0; k < 6; k++) begin
            r = $urandom();
            bist_sig_i = r[15:0]; bist_busy_i = r[16]; bist_done_i = r[17];
            scan(1'b0, 20, 32'h0, 1'b0, d);
            check("R10 result capture", d[19:0], exp_rdr(m_sel, r[16], r[17], r[15:0]));
        end

        // R1 mid-run reset
        @(negedge wrck);
        wrstn = 1'b0;
        #1;
        check("R1 async clear", {pattern_count_o, result_sel_o, bnd_upd_o, ext_mode_o}, '0);
        @(negedge wrck);
        wrstn = 1'b1;
        m_cnt = '0; m_sel = '0; m_word = '0; m_bnd = '0;
        r = $urandom();
        scan(1'b0, 8, r, 1'b1, d);
        check("R1 R3 bypass after reset", d[7:0], {r[6:0], 1'b0});
        load_ir(3'b010);
        scan(1'b0, 16, 32'h0, 1'b0, d);
        check("R1 cmd cleared", d[15:0], 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule